// File: doc/BRIEF.md
# Switching Clock Source Selector

This block picks the cycle clock for a switching regulator controller. It either counts a free-running internal period on the fast system clock or follows rising edges on an external synchronization pin. It sends out one single-cycle `cycle_start` pulse for each regulator cycle. The `ext_active` flag shows which source is in use. A one-cycle `sync_lost` strobe marks the moment the external source is dropped.

The sync pin passes through a two-flop synchronizer. A rising edge is a sampled low followed by a sampled high. The first such edge moves the block onto the external source at once, with no qualification period. A watchdog restarts on every accepted edge. If no edge arrives within two internal periods, the block returns to the internal source. The internal counter then restarts from that moment, so the next pulse comes exactly one internal period later: there is no gap and no doubled pulse. While the soft-start input is high, the sync pin is ignored and cycles come from the internal counter.

Top module: `swclk_source_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cycle_start`, `ext_active` and `sync_lost` are all low after that edge.
- R2: While the internal source is selected, `cycle_start` pulses exactly once every `INT_PERIOD` system clocks.
- R3: A low-to-high change on `sync_in` that is set up before edge k makes `ext_active` and `cycle_start` high after edge k+2. A level held high produces no further edges.
- R4: While the external source is selected, `cycle_start` pulses once for each accepted sync rising edge and at no other time.
- R5: If an accepted edge produced a pulse after edge a and no later edge is accepted, `ext_active` falls after edge a+2·`INT_PERIOD`. `sync_lost` is high for exactly that one cycle, and `cycle_start` is low in it.
- R6: After a fallback, the next `cycle_start` comes exactly `INT_PERIOD` clocks after the cycle in which `sync_lost` is high. The internal cadence of R2 follows from there.
- R7: While `softstart_active` is high, sync edges are ignored. `ext_active` is low after the first edge that sees soft start, and pulses follow the internal cadence.
- R8: An accepted edge no later than 2·`INT_PERIOD` clocks after the previous one keeps the external source. One that arrives later re-locks after a fallback, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Asynchronous external synchronization pin |
| softstart_active | input | 1 | High while the soft-start ramp runs; masks `sync_in` |
| cycle_start | output | 1 | Single-cycle pulse that starts a regulator cycle |
| ext_active | output | 1 | High while the external source is selected |
| sync_lost | output | 1 | One-cycle strobe when the watchdog drops the external source |

## Verification
A sync rise set up before edge k is due on `cycle_start` and `ext_active` after edge k+2, once it has passed the two synchronizer flops and the output register. A watchdog fallback is due 2·`INT_PERIOD` edges after the pulse of the last accepted edge, and the next internal pulse comes `INT_PERIOD` edges after that. The bench drives inputs just after a rising edge and samples one time unit after the next rising edge. For each iteration it computes the expected pulse, flag and strobe from these counts. It sweeps every external period from 3 to 20 clocks with `INT_PERIOD` = 8. That sweep covers the exact timeout boundary of 16 clocks and the periods beyond it, where the block falls back and then re-locks.

// File: rtl/swsel_pkg.sv
// Shared types for the switching clock source selector.
// Assumes nothing beyond a single system clock domain.
package swsel_pkg;
    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } clk_src_e;
endpackage

// File: rtl/swsel_sync_edge.sv
// Brings the asynchronous sync pin into the clk domain through STAGES
// flops and flags a rising edge (sampled 0 then sampled 1).
// Assumes STAGES >= 2 and that the pin holds each level for at least one clk.
module swsel_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise_det
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    // Synchronizer chain: stage 0 samples the pin, each stage feeds the next.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin_async;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // One further synchronizer stage.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    // Previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain[STAGES-1];
    end

    assign rise_det = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/swsel_period_gen.sv
// Free-running internal cycle counter. Ticks once every PERIOD clocks.
// A restart puts the phase back to zero, so the next tick is PERIOD clocks later.
// Assumes PERIOD >= 2.
module swsel_period_gen #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] phase;

    // Phase counter: wraps at LAST, restarts on request.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);
endmodule

// File: rtl/swsel_loss_wdog.sv
// Counts clocks since the last accepted sync edge. Flags expiry when LIMIT
// clocks have passed with no clear. Assumes LIMIT >= 2.
module swsel_loss_wdog #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Elapsed-time counter: cleared by an edge or when idle, saturates at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LAST) & ~clear;
endmodule

// File: rtl/swclk_source_sel.sv
// Top of the switching clock source selector. It chooses between the internal
// period counter and the external sync pin. The first sync edge locks to the
// external source. A watchdog of TIMEOUT_PERIODS internal periods drops back to
// internal. Soft start masks the pin. Assumes sync_in is asynchronous to clk.
module swclk_source_sel #(
    parameter int INT_PERIOD      = 16,
    parameter int TIMEOUT_PERIODS = 2,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic softstart_active,
    output logic cycle_start,
    output logic ext_active,
    output logic sync_lost
);
    import swsel_pkg::*;

    localparam int WD_LIMIT = INT_PERIOD * TIMEOUT_PERIODS;

    clk_src_e src_q;
    logic     rise_det;
    logic     edge_ok;
    logic     int_tick;
    logic     wd_expired;
    logic     fallback;

    swsel_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (sync_in),
        .rise_det  (rise_det)
    );

    assign edge_ok  = rise_det & ~softstart_active;
    assign fallback = (src_q == SRC_EXT) & ~softstart_active & ~edge_ok & wd_expired;

    swsel_period_gen #(.PERIOD(INT_PERIOD)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fallback),
        .tick    (int_tick)
    );

    swsel_loss_wdog #(.LIMIT(WD_LIMIT)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (edge_ok | softstart_active | (src_q == SRC_INT)),
        .expired (wd_expired)
    );

    // Source selection: soft start forces internal, an edge locks, a timeout drops.
    always_ff @(posedge clk) begin
        if (!rst_n)                src_q <= SRC_INT;
        else if (softstart_active) src_q <= SRC_INT;
        else if (edge_ok)          src_q <= SRC_EXT;
        else if (fallback)         src_q <= SRC_INT;
    end

    // Output pulses: cycle start from the active source, loss strobe on fallback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle_start <= 1'b0;
            sync_lost   <= 1'b0;
        end else begin
            cycle_start <= edge_ok | (((src_q == SRC_INT) | softstart_active) & int_tick);
            sync_lost   <= fallback;
        end
    end

    assign ext_active = (src_q == SRC_EXT);
endmodule

// File: rtl/swsel_checker.sv
// Property checker for swclk_source_sel, attached with bind below.
// Assumes LIMIT equals the watchdog window in clocks.
module swsel_checker #(
    parameter int LIMIT = 32
) (
    input logic clk,
    input logic rst_n,
    input logic softstart_active,
    input logic cycle_start,
    input logic ext_active,
    input logic sync_lost
);
    localparam int GW = $clog2(LIMIT) + 1;
    logic [GW-1:0] gap;

    // Clocks since the last pulse while locked to the external source.
    always_ff @(posedge clk) begin
        if (!rst_n || cycle_start || !ext_active) gap <= '0;
        else                                      gap <= gap + 1'b1;
    end

    assert_lock_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_active) |-> cycle_start);

    assert_lost_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |-> (!ext_active && $past(ext_active)));

    assert_lost_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |-> !cycle_start);

    assert_ss_internal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        softstart_active |=> !ext_active);

    assert_gap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_active |-> (gap < GW'(LIMIT)));
endmodule

bind swclk_source_sel swsel_checker #(.LIMIT(WD_LIMIT)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .softstart_active (softstart_active),
    .cycle_start      (cycle_start),
    .ext_active       (ext_active),
    .sync_lost        (sync_lost)
);

// File: tb/sim_swclk_source_sel.sv
module sim_swclk_source_sel;
    localparam int P   = 8;
    localparam int LIM = 2 * P;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic ss = 1'b0;
    logic cycle_start, ext_active, sync_lost;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    swclk_source_sel #(.INT_PERIOD(P), .TIMEOUT_PERIODS(2), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .softstart_active(ss),
        .cycle_start(cycle_start), .ext_active(ext_active), .sync_lost(sync_lost)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Drive rises every E clocks N times, then idle; compare each iteration.
    task automatic run_ext(int E, int N);
        bit ee = 0;
        int last = -100;
        int nxt = -1;
        int bp = 0, be = 0, bw = 0;
        int ap = 0, xp = 0, ae = 0, xe = 0, aw = 0, xw = 0;
        sync_in = 1'b0;
        repeat (3) step();
        for (int k = 0; k < N * E + 40; k++) begin
            bit exp_p = 0;
            bit exp_w = 0;
            sync_in = (k < N * E) && ((k % E) < (E + 1) / 2);
            step();
            if (k >= 2 && (k - 2) < N * E && ((k - 2) % E) == 0) begin
                exp_p = 1; ee = 1; last = k; nxt = -1;
            end else if (ee && k == last + LIM) begin
                ee = 0; exp_w = 1; nxt = k + P;
            end else if (!ee && nxt >= 0 && k == nxt) begin
                exp_p = 1; nxt = k + P;
            end
            if (k >= 2) begin
                if (ext_active != ee && be == 0) begin be = 1; ae = ext_active; xe = ee; end
                if (sync_lost != exp_w && bw == 0) begin bw = 1; aw = sync_lost; xw = exp_w; end
                if ((ee || nxt >= 0 || exp_p) && cycle_start != exp_p && bp == 0) begin
                    bp = 1; ap = cycle_start; xp = exp_p;
                end
            end
        end
        // R4 R6: pulses follow edges while locked, then the internal restart
        check($sformatf("R4 R6 pulses E=%0d", E), ap, xp);
        // R3 R8: lock flag timing, kept or lost per the edge spacing
        check($sformatf("R3 R8 ext_active E=%0d", E), ae, xe);
        // R5: loss strobe exactly 2*P after the last accepted pulse
        check($sformatf("R5 sync_lost E=%0d", E), aw, xw);
    endtask

    initial begin
        int prev;
        int bad;
        int cnt;
        int seen;

        // R1: reset state
        rst_n = 1'b0;
        sync_in = 1'b1;
        repeat (3) step();
        check("R1 cycle_start in reset", cycle_start, 0);
        check("R1 ext_active in reset", ext_active, 0);
        check("R1 sync_lost in reset", sync_lost, 0);
        sync_in = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;

        // R2: internal cadence with sync idle
        prev = -1; bad = 0; cnt = 0;
        for (int k = 0; k < 60; k++) begin
            step();
            if (cycle_start) begin
                if (prev >= 0 && k - prev != P && bad == 0) bad = k - prev;
                prev = k; cnt++;
            end
        end
        check("R2 internal spacing", bad, 0);
        check("R2 internal pulse count", cnt, 60 / P);

        // R3 R4 R5 R6 R8: sweep of external periods across the timeout boundary
        for (int e = 3; e <= 20; e++) run_ext(e, 3);

        // R7: soft start while locked
        seen = 0;
        for (int k = 0; k < 30; k++) begin
            sync_in = (k % 6) < 3;
            step();
        end
        check("R7 locked before soft start", ext_active, 1);
        ss = 1'b1;
        prev = -1; bad = 0; cnt = 0;
        for (int k = 30; k < 110; k++) begin
            sync_in = (k % 6) < 3;
            step();
            if (ext_active) seen++;
            if (cycle_start) begin
                if (prev >= 0 && k - prev != P && bad == 0) bad = k - prev;
                prev = k; cnt++;
            end
        end
        check("R7 ext_active during soft start", seen, 0);
        check("R7 internal spacing during soft start", bad, 0);
        check("R7 pulse count during soft start", (cnt >= 9) ? 1 : 0, 1);
        ss = 1'b0;
        bad = 1;
        for (int k = 110; k < 120; k++) begin
            sync_in = (k % 6) < 3;
            step();
            if (ext_active && bad == 1) bad = cycle_start ? 0 : 2;
        end
        check("R3 relock after soft start", bad, 0);

        // R1: reset while locked
        rst_n = 1'b0;
        step();
        check("R1 ext_active after mid-run reset", ext_active, 0);
        check("R1 cycle_start after mid-run reset", cycle_start, 0);
        sync_in = 1'b0;
        rst_n = 1'b1;
        repeat (4) step();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule